// File: doc/BRIEF.md
# Pipelined Debug Block-Read Sequencer

This block is a host-side engine that fetches a run of 32-bit words from target memory through a debug access port. It owns a simple scan-request/response channel. Each request names a port-level or access-level register, gives a read or write direction and carries write data. Each response returns an acknowledge code and 32 bits of data. The physical shifting of bits is left to whatever serves that channel. A host gives a start address, a word count and a one-cycle start strobe. The engine returns the words in address order on a valid-qualified stream, followed by a done pulse that may carry an error flag.

The engine cuts the run into segments that never cross a 4 KB page. For each segment it programs the transfer address and then issues back-to-back data reads. The target returns every read result one scan late, so each new read also collects the word before it. A read of the read-buffer register then collects the last word. The engine finishes each segment by checking port status. That check polls while the target answers WAIT, but only up to a fixed limit, and it clears sticky error flags when they are set. A failing segment is run again once from the same address. The bank-select and control words are cached, so they are written only when a change is needed.

Words are held in a one-page buffer until their segment passes its check. The host therefore never sees data from an attempt that was thrown away.

Top module: `dbr_block_reader`

## Requirements
- R1: A start with a word count of zero raises done, with error low, on the clock edge after the start strobe and issues no scan.
- R2: The select write (port register 2, value {AP_SEL, 24'h0}) and the control-word write (access register 0, value CSW_WORD) are issued only when they differ from the last value written since reset. After reset the first operation issues both, and later operations issue neither.
- R3: Segment lengths follow (PAGE_BYTES − (address mod PAGE_BYTES))/4, capped by the words still to read. Every segment, retries included, begins with a write of its start address to access register 1.
- R4: A segment of N words issues N reads of access register 3 and then one read of port register 3. The data of the first response is dropped, and each later response carries the previous word.
- R5: After the data reads, port register 1 is read twice. Only the acknowledge of the second read and of any poll after it is judged: 3'b001 (WAIT) re-reads and 3'b010 (OK) accepts the returned status.
- R6: 100 WAIT answers in one check are tolerated. The 101st fails the segment.
- R7: An acknowledge other than WAIT or OK on a judged status read fails the segment.
- R8: An OK status with bit 1 or bit 5 set fails the segment and triggers a write to port register 1 of CTRL_KEEP | 32'h22 before anything else.
- R9: A failed segment is retried from the same address. The second failure within one operation ends it with done and error together.
- R10: Words leave in ascending address order, each exactly once, and only after their segment's check passes. No word from a failed attempt is ever emitted.
- R11: done is a one-cycle pulse that comes one cycle after the last word. error is high only together with done, and busy is high from the start strobe until done.
- R12: scan_req is a one-cycle pulse, and no new request is made until a response has come back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| start_addr | input | 32 | First word address (bits 1:0 ignored) |
| word_count | input | CNT_W | Number of words to read |
| busy | output | 1 | Operation in progress |
| scan_req | output | 1 | Scan request pulse |
| scan_ap | output | 1 | 1 = access-port register, 0 = port register |
| scan_reg | output | 2 | Register index (address bits 3:2) |
| scan_rnw | output | 1 | 1 = read, 0 = write |
| scan_wdata | output | 32 | Write data of the request |
| scan_rsp | input | 1 | Response strobe for the outstanding request |
| scan_ack | input | 3 | Acknowledge code of the response |
| scan_rdata | input | 32 | Data of the response (result of the previous read) |
| word_valid | output | 1 | word_data holds an accepted word |
| word_data | output | 32 | Read word |
| done | output | 1 | Operation finished |
| error | output | 1 | Operation failed (only with done) |

## Verification
Some rules hold on every cycle and are checked by the embedded properties. These are the single-pulse shape of requests and of done, error appearing only alongside done, and requests appearing only while busy. They also cover words being emitted only from the drain phase that follows a passed status check, the WAIT counter staying within its limit, and the buffer write pointer never passing the segment length. The target-side behaviours can only be shown by the bench's scripted target model. These are the page split, the cache suppression of select and control writes, the WAIT limit at exactly 100 versus 101, bad acknowledges, sticky-flag clearing, the single retry from the same address, and the discarding of data from a failed attempt.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_CSW, S_TAR, S_DRW, S_RDBUF,
    S_ST1, S_ST2, S_CLR, S_FAIL, S_DRAIN
  } dbr_state_e;

  // port register indices (address bits 3:2)
  localparam logic [1:0] PREG_CTRL  = 2'd1;
  localparam logic [1:0] PREG_SEL   = 2'd2;
  localparam logic [1:0] PREG_RDBUF = 2'd3;
  // access register indices within bank 0
  localparam logic [1:0] AREG_CSW = 2'd0;
  localparam logic [1:0] AREG_TAR = 2'd1;
  localparam logic [1:0] AREG_DRW = 2'd3;

  localparam logic [2:0] ACK_WAIT = 3'd1;
  localparam logic [2:0] ACK_OK   = 3'd2;

  localparam logic [31:0] STICKY_MASK = 32'h0000_0022;
endpackage

// File: rtl/dbr_seg_len.sv
module dbr_seg_len #(
  parameter int PAGE_BYTES = 4096,
  parameter int CNT_W      = 16,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int LEN_W     = OFS_W - 1
) (
  input  logic [OFS_W-1:0] addr_lo,
  input  logic [CNT_W-1:0] remain,
  output logic [LEN_W-1:0] seg_len
);
  logic [OFS_W:0] room_b;
  logic [31:0]    room32;
  logic [31:0]    rem32;

  always_comb begin
    room_b  = (OFS_W+1)'(PAGE_BYTES) - {1'b0, addr_lo};
    room32  = 32'(room_b[OFS_W:2]);
    rem32   = 32'(remain);
    seg_len = (rem32 < room32) ? LEN_W'(rem32) : LEN_W'(room32);
  end
endmodule

// File: rtl/dbr_word_buf.sv
module dbr_word_buf #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dbr_block_reader.sv
module dbr_block_reader
  import dbr_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          PAGE_BYTES = 4096,
  parameter int          MAX_WAIT   = 100,
  parameter logic [7:0]  AP_SEL     = 8'h00,
  parameter logic [31:0] CSW_WORD   = 32'h2300_0012,
  parameter logic [31:0] CTRL_KEEP  = 32'h5000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [31:0]      start_addr,
  input  logic [CNT_W-1:0] word_count,
  output logic             busy,
  output logic             scan_req,
  output logic             scan_ap,
  output logic [1:0]       scan_reg,
  output logic             scan_rnw,
  output logic [31:0]      scan_wdata,
  input  logic             scan_rsp,
  input  logic [2:0]       scan_ack,
  input  logic [31:0]      scan_rdata,
  output logic             word_valid,
  output logic [31:0]      word_data,
  output logic             done,
  output logic             error
);
  localparam int DEPTH = PAGE_BYTES / 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int LEN_W = OFS_W - 1;
  localparam int WC_W  = $clog2(MAX_WAIT + 1);
  localparam logic [31:0] SEL_WANT = {AP_SEL, 24'h0};

  dbr_state_e       state;
  logic             wait_rsp;
  logic [31:0]      seg_addr;
  logic [CNT_W-1:0] remain;
  logic [LEN_W-1:0] seg_len_w, seg_len_q, rd_idx, wr_ptr, rd_ptr;
  logic [WC_W-1:0]  wait_cnt;
  logic             retried;
  logic             sel_valid, csw_valid;
  logic [31:0]      sel_last, csw_last;
  logic             got, buf_we, buf_re;

  assign got = wait_rsp && scan_rsp;
  assign buf_we = got && (((state == S_DRW) && (rd_idx > LEN_W'(1))) || (state == S_RDBUF));
  assign buf_re = (state == S_DRAIN) && (rd_ptr != seg_len_q);

  dbr_seg_len #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_len (
    .addr_lo(seg_addr[OFS_W-1:0]), .remain(remain), .seg_len(seg_len_w)
  );

  dbr_word_buf #(.DEPTH(DEPTH), .DW(32)) u_buf (
    .clk(clk), .we(buf_we), .waddr(wr_ptr[AW-1:0]), .wdata(scan_rdata),
    .re(buf_re), .raddr(rd_ptr[AW-1:0]), .rdata(word_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      wait_rsp   <= 1'b0;
      seg_addr   <= '0;
      remain     <= '0;
      seg_len_q  <= '0;
      rd_idx     <= '0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      wait_cnt   <= '0;
      retried    <= 1'b0;
      sel_valid  <= 1'b0;
      csw_valid  <= 1'b0;
      sel_last   <= '0;
      csw_last   <= '0;
      busy       <= 1'b0;
      scan_req   <= 1'b0;
      scan_ap    <= 1'b0;
      scan_reg   <= '0;
      scan_rnw   <= 1'b0;
      scan_wdata <= '0;
      word_valid <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      scan_req   <= 1'b0;
      word_valid <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
      if (got) wait_rsp <= 1'b0;

      case (state)
        S_IDLE: begin
          if (start) begin
            if (word_count == '0) begin
              done <= 1'b1;
            end else begin
              seg_addr <= start_addr & ~32'h3;
              remain   <= word_count;
              retried  <= 1'b0;
              busy     <= 1'b1;
              state    <= S_SEL;
            end
          end
        end

        S_SEL: begin
          if (sel_valid && sel_last == SEL_WANT) begin
            state <= S_CSW;
          end else if (!wait_rsp) begin
            scan_req <= 1'b1; wait_rsp <= 1'b1;
            scan_ap <= 1'b0; scan_reg <= PREG_SEL; scan_rnw <= 1'b0;
            scan_wdata <= SEL_WANT;
          end else if (got) begin
            sel_valid <= 1'b1;
            sel_last  <= SEL_WANT;
            state     <= S_CSW;
          end
        end

        S_CSW: begin
          if (csw_valid && csw_last == CSW_WORD) begin
            state <= S_TAR;
          end else if (!wait_rsp) begin
            scan_req <= 1'b1; wait_rsp <= 1'b1;
            scan_ap <= 1'b1; scan_reg <= AREG_CSW; scan_rnw <= 1'b0;
            scan_wdata <= CSW_WORD;
          end else if (got) begin
            csw_valid <= 1'b1;
            csw_last  <= CSW_WORD;
            state     <= S_TAR;
          end
        end

        S_TAR: begin
          if (!wait_rsp) begin
            scan_req <= 1'b1; wait_rsp <= 1'b1;
            scan_ap <= 1'b1; scan_reg <= AREG_TAR; scan_rnw <= 1'b0;
            scan_wdata <= seg_addr;
            seg_len_q <= seg_len_w;
            rd_idx    <= '0;
            wr_ptr    <= '0;
          end else if (got) begin
            state <= S_DRW;
          end
        end

        S_DRW: begin
          if (!wait_rsp) begin
            scan_req <= 1'b1; wait_rsp <= 1'b1;
            scan_ap <= 1'b1; scan_reg <= AREG_DRW; scan_rnw <= 1'b1;
            scan_wdata <= '0;
            rd_idx <= rd_idx + 1'b1;
          end else if (got) begin
            if (buf_we) wr_ptr <= wr_ptr + 1'b1;
            if (rd_idx == seg_len_q) state <= S_RDBUF;
          end
        end

        S_RDBUF: begin
          if (!wait_rsp) begin
            scan_req <= 1'b1; wait_rsp <= 1'b1;
            scan_ap <= 1'b0; scan_reg <= PREG_RDBUF; scan_rnw <= 1'b1;
            scan_wdata <= '0;
          end else if (got) begin
            wr_ptr <= wr_ptr + 1'b1;
            state  <= S_ST1;
          end
        end

        S_ST1: begin
          if (!wait_rsp) begin
            scan_req <= 1'b1; wait_rsp <= 1'b1;
            scan_ap <= 1'b0; scan_reg <= PREG_CTRL; scan_rnw <= 1'b1;
            scan_wdata <= '0;
          end else if (got) begin
            wait_cnt <= '0;
            state    <= S_ST2;
          end
        end

        S_ST2: begin
          if (!wait_rsp) begin
            scan_req <= 1'b1; wait_rsp <= 1'b1;
            scan_ap <= 1'b0; scan_reg <= PREG_CTRL; scan_rnw <= 1'b1;
            scan_wdata <= '0;
          end else if (got) begin
            if (scan_ack == ACK_OK) begin
              if ((scan_rdata & STICKY_MASK) != '0) begin
                state <= S_CLR;
              end else begin
                rd_ptr <= '0;
                state  <= S_DRAIN;
              end
            end else if (scan_ack == ACK_WAIT) begin
              if (wait_cnt == WC_W'(MAX_WAIT)) state <= S_FAIL;
              else wait_cnt <= wait_cnt + 1'b1;
            end else begin
              state <= S_FAIL;
            end
          end
        end

        S_CLR: begin
          if (!wait_rsp) begin
            scan_req <= 1'b1; wait_rsp <= 1'b1;
            scan_ap <= 1'b0; scan_reg <= PREG_CTRL; scan_rnw <= 1'b0;
            scan_wdata <= CTRL_KEEP | STICKY_MASK;
          end else if (got) begin
            state <= S_FAIL;
          end
        end

        S_FAIL: begin
          if (retried) begin
            done  <= 1'b1;
            error <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            retried <= 1'b1;
            state   <= S_TAR;
          end
        end

        S_DRAIN: begin
          if (buf_re) begin
            rd_ptr     <= rd_ptr + 1'b1;
            word_valid <= 1'b1;
          end else begin
            seg_addr <= seg_addr + 32'({seg_len_q, 2'b00});
            remain   <= remain - CNT_W'(seg_len_q);
            if (remain == CNT_W'(seg_len_q)) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              state <= S_TAR;
            end
          end
        end

        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst) error |-> done);
  // R12
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst) scan_req |=> !scan_req);
  // R12
  req_busy_chk: assert property (@(posedge clk) disable iff (rst) scan_req |-> busy);
  // R10
  valid_after_pass_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ($past(state) == S_DRAIN));
  // R6
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst) wait_cnt <= WC_W'(MAX_WAIT));
  // R4
  wrptr_bound_chk: assert property (@(posedge clk) disable iff (rst) wr_ptr <= seg_len_q);
  // R3
  seg_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_DRW) |-> (seg_len_q != '0 && 32'(seg_len_q) <= DEPTH));
endmodule

// File: tb/tb_dbr_block_reader.sv
module tb_dbr_block_reader;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEEP = 32'h5000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] word_count = '0;
  logic        busy, scan_req, scan_ap, scan_rnw, word_valid, done, error;
  logic [1:0]  scan_reg;
  logic [31:0] scan_wdata, word_data;
  logic        scan_rsp = 1'b0;
  logic [2:0]  scan_ack = 3'd0;
  logic [31:0] scan_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbr_block_reader #(.CTRL_KEEP(KEEP)) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .word_count(word_count), .busy(busy), .scan_req(scan_req),
    .scan_ap(scan_ap), .scan_reg(scan_reg), .scan_rnw(scan_rnw),
    .scan_wdata(scan_wdata), .scan_rsp(scan_rsp), .scan_ack(scan_ack),
    .scan_rdata(scan_rdata), .word_valid(word_valid), .word_data(word_data),
    .done(done), .error(error)
  );

  int n_tests = 0, n_fail = 0;
  int n_sel, n_csw, n_tar, n_drw, n_ctrl, n_clr, n_scan;
  int wait_left = 0, bad_left = 0;
  bit sticky_persist = 0;
  logic [31:0] ctrlstat = '0, pend = '0, tar = '0, clr_data = '0;
  logic [31:0] tar_log [8];
  logic [31:0] got_w [64];
  int n_got = 0;
  logic op_err;

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return a ^ 32'h5A00_C3C3;
  endfunction

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    n_sel = 0; n_csw = 0; n_tar = 0; n_drw = 0; n_ctrl = 0; n_clr = 0; n_scan = 0;
  endtask

  // target model
  initial begin
    logic [2:0]  r_ack;
    logic [31:0] r_data;
    clr_counts();
    forever begin
      @(negedge clk);
      if (scan_req) begin
        r_ack = 3'd2; r_data = '0; n_scan++;
        if (scan_ap && !scan_rnw && scan_reg == 2'd0) n_csw++;
        else if (scan_ap && !scan_rnw && scan_reg == 2'd1) begin
          tar = scan_wdata;
          if (n_tar < 8) tar_log[n_tar] = scan_wdata;
          n_tar++;
          if (sticky_persist) ctrlstat[5] = 1'b1;
        end else if (scan_ap && scan_rnw && scan_reg == 2'd3) begin
          r_data = pend; pend = memfn(tar); tar = tar + 4; n_drw++;
        end else if (!scan_ap && scan_rnw && scan_reg == 2'd3) begin
          r_data = pend;
        end else if (!scan_ap && scan_rnw && scan_reg == 2'd1) begin
          r_data = pend; pend = ctrlstat; n_ctrl++;
          if (bad_left > 0) begin r_ack = 3'd4; bad_left--; end
          else if (wait_left > 0) begin r_ack = 3'd1; wait_left--; end
        end else if (!scan_ap && !scan_rnw && scan_reg == 2'd1) begin
          n_clr++; clr_data = scan_wdata;
          ctrlstat = ctrlstat & ~(scan_wdata & 32'h22);
        end else if (!scan_ap && !scan_rnw && scan_reg == 2'd2) n_sel++;
        @(negedge clk);
        scan_rsp = 1'b1; scan_ack = r_ack; scan_rdata = r_data;
        @(negedge clk);
        scan_rsp = 1'b0;
      end
    end
  end

  // word collector
  initial begin
    forever begin
      @(negedge clk);
      if (word_valid) begin
        if (n_got < 64) got_w[n_got] = word_data;
        n_got++;
      end
    end
  end

  task automatic run_op(input logic [31:0] addr, input int cnt);
    clr_counts();
    n_got = 0;
    @(negedge clk);
    start_addr = addr; word_count = 16'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    op_err = error;
    chk_eq("R11 done seen", 32'(done), 32'd1);
    @(negedge clk);
  endtask

  task automatic chk_words(input string req, input logic [31:0] addr, input int cnt);
    chk_eq({req, " word count"}, 32'(n_got), 32'(cnt));
    for (int i = 0; i < cnt && i < 64; i++)
      chk_eq({req, " word"}, got_w[i], memfn(addr + 32'(4*i)));
  endtask

  task automatic t_reset();
    chk_eq("R11 reset busy", 32'(busy), 0);
    chk_eq("R11 reset done", 32'(done), 0);
    chk_eq("R12 reset req", 32'(scan_req), 0);
    chk_eq("R10 reset valid", 32'(word_valid), 0);
  endtask

  task automatic t_zero();
    clr_counts();
    @(negedge clk);
    word_count = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_eq("R1 done", 32'(done), 1);
    chk_eq("R1 error", 32'(error), 0);
    repeat (5) @(negedge clk);
    chk_eq("R1 no scans", 32'(n_scan), 0);
  endtask

  task automatic t_first();
    run_op(32'h2000_0100, 5);
    chk_eq("R11 error", 32'(op_err), 0);
    chk_eq("R2 select writes", 32'(n_sel), 1);
    chk_eq("R2 control writes", 32'(n_csw), 1);
    chk_eq("R3 addr writes", 32'(n_tar), 1);
    chk_eq("R3 addr value", tar_log[0], 32'h2000_0100);
    chk_eq("R4 data reads", 32'(n_drw), 5);
    chk_eq("R5 status reads", 32'(n_ctrl), 2);
    chk_words("R10", 32'h2000_0100, 5);
  endtask

  task automatic t_cached();
    run_op(32'h2000_0200, 3);
    chk_eq("R2 select suppressed", 32'(n_sel), 0);
    chk_eq("R2 control suppressed", 32'(n_csw), 0);
    chk_words("R4", 32'h2000_0200, 3);
  endtask

  task automatic t_page();
    run_op(32'h0000_0FF8, 4);
    chk_eq("R3 segments", 32'(n_tar), 2);
    chk_eq("R3 seg0 addr", tar_log[0], 32'h0000_0FF8);
    chk_eq("R3 seg1 addr", tar_log[1], 32'h0000_1000);
    chk_eq("R4 reads", 32'(n_drw), 4);
    chk_words("R10 page", 32'h0000_0FF8, 4);
  endtask

  task automatic t_wait100();
    wait_left = 101;
    run_op(32'h1000_0040, 2);
    chk_eq("R6 100 waits ok", 32'(op_err), 0);
    chk_eq("R6 no retry", 32'(n_tar), 1);
    chk_words("R6", 32'h1000_0040, 2);
  endtask

  task automatic t_wait101();
    wait_left = 102;
    run_op(32'h3000_0000, 3);
    chk_eq("R6 retried ok", 32'(op_err), 0);
    chk_eq("R9 retry count", 32'(n_tar), 2);
    chk_eq("R9 same addr", tar_log[1], tar_log[0]);
    chk_words("R10 once", 32'h3000_0000, 3);
  endtask

  task automatic t_badack();
    bad_left = 2;
    run_op(32'h3000_0100, 2);
    chk_eq("R7 retried", 32'(n_tar), 2);
    chk_eq("R7 ok after retry", 32'(op_err), 0);
    chk_words("R7", 32'h3000_0100, 2);
  endtask

  task automatic t_sticky();
    ctrlstat[1] = 1'b1;
    run_op(32'h4000_0010, 3);
    chk_eq("R8 clear writes", 32'(n_clr), 1);
    chk_eq("R8 clear value", clr_data, KEEP | 32'h22);
    chk_eq("R8 ok after retry", 32'(op_err), 0);
    chk_words("R8", 32'h4000_0010, 3);
  endtask

  task automatic t_twofail();
    sticky_persist = 1;
    run_op(32'h4000_0100, 2);
    sticky_persist = 0;
    ctrlstat = '0;
    chk_eq("R9 error", 32'(op_err), 1);
    chk_eq("R9 attempts", 32'(n_tar), 2);
    chk_eq("R10 no words", 32'(n_got), 0);
  endtask

  task automatic t_waitforever();
    wait_left = 1000;
    run_op(32'h5000_0000, 1);
    wait_left = 0;
    chk_eq("R6 timeout error", 32'(op_err), 1);
    chk_eq("R10 no words", 32'(n_got), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero();
    t_first();
    t_cached();
    t_page();
    t_wait100();
    t_wait101();
    t_badack();
    t_sticky();
    t_twofail();
    t_waitforever();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule